// File: doc/BRIEF.md
# Adapter Probe and Configuration Sequencer

This block identifies a network adapter on a shared bus and works out where its on-board buffer memory should appear and which interrupt line it uses. After a start pulse it holds the adapter in reset for a programmable number of cycles. It then reads an identification port four times and builds a 16-bit board identifier from the tagged nibbles it receives. Next it asks an external serial-EEPROM reader for configuration words. It checks every decoded value against optional preset values, and then programs three window-decode registers.

The EEPROM reader is a simple request/acknowledge port: the sequencer presents a word address and waits for the word. The memory configuration is a one-byte mask. Its lowest set bit selects a 16 KiB page above 0xC0000, and the run of ones above that bit gives the window size. A 16-bit checksum over the first 64 EEPROM words is taken while the network controller is held inactive. A 3-bit interrupt code is mapped to a bus interrupt number. The probe ends in a done state that reports pass or fail together with the decoded window and interrupt.

Top module: `probe_cfg_seq`

## Requirements
- R1: While reset is asserted and until the first start, done, pass, hw_reset, id_rd, ee_req, ctl_hold and reg_wr are all low.
- R2: On start, hw_reset is high for exactly RST_CYCLES (default 8) consecutive cycles. It is followed at once by exactly four consecutive id_rd cycles, and id_data is sampled in each of them.
- R3: For each ID read, id_data[7:4] is placed at bit position 4*id_data[1:0] and ORed into the board ID. If the result differs from ID_EXPECT (default 0xBABA), the probe ends failed without any EEPROM request.
- R4: The low byte of EEPROM word 6 is the memory mask. Its lowest set bit index i gives win_base = 0xC0000 + i*0x4000. A zero byte fails the probe after that single EEPROM read.
- R5: The mask shifted right by i must be 0x01, 0x03, 0x07 or 0x0F, which gives win_size = 16, 32, 48 or 64 KiB in bytes. Any other value fails the probe after that single read.
- R6: The checksum requests EEPROM words 0 to 63 in ascending order. ctl_hold is high from the first of these requests until done. The 16-bit wrapping sum must equal ID_EXPECT, or the probe ends failed with no register write.
- R7: After a good checksum, reg_wr is high for three consecutive cycles with reg_sel 0, 1 and 2 in turn. The data written is, in order: the decode low byte, its bitwise inverse, and the extended decode byte. The decode value is ((1 << k) - 1) << pg, with k the size in 16 KiB units and pg = win_base[17:14].
- R8: The extended decode byte equals ((~decode >> 4) & 0xF0) | (decode >> 8), computed on 16 bits.
- R9: Bits [15:13] of EEPROM word 1 are the interrupt code. irq_num maps codes 0 to 7 to 0, 9, 3, 4, 5, 10, 11 and 0.
- R10: If a preset valid flag is high, a decoded base, size or interrupt number that differs from the preset value fails the probe. With the flag low, the decoded value is accepted.
- R11: done stays high and pass stays constant until the next start. pass is never high without done, and a new start runs the whole sequence again.
- R12: ee_req stays high with ee_addr unchanged until ee_ack. ee_data is taken in the ack cycle, and each request consumes exactly one ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a probe |
| pre_base_vld | input | 1 | Preset base is supplied |
| pre_base | input | 20 | Preset window base address |
| pre_size_vld | input | 1 | Preset size is supplied |
| pre_size | input | 17 | Preset window size in bytes |
| pre_irq_vld | input | 1 | Preset interrupt is supplied |
| pre_irq | input | 4 | Preset interrupt number |
| hw_reset | output | 1 | Adapter reset pulse |
| id_rd | output | 1 | ID port read strobe |
| id_data | input | 8 | ID port read data |
| ee_req | output | 1 | EEPROM word request |
| ee_addr | output | 6 | EEPROM word address |
| ee_ack | input | 1 | EEPROM word valid |
| ee_data | input | 16 | EEPROM word |
| ctl_hold | output | 1 | Keep network controller in reset |
| reg_wr | output | 1 | Decode register write strobe |
| reg_sel | output | 2 | Decode register select |
| reg_wdata | output | 8 | Decode register data |
| done | output | 1 | Probe finished |
| pass | output | 1 | Probe succeeded |
| win_base | output | 20 | Decoded window base |
| win_size | output | 17 | Decoded window size in bytes |
| dec_lo | output | 8 | Decode low byte |
| dec_inv | output | 8 | Inverted decode low byte |
| dec_ext | output | 8 | Extended decode byte |
| irq_num | output | 4 | Mapped interrupt number |

## Verification
A state machine that skips or repeats a phase shows up at the ports straight away. The reset pulse is the wrong length, the ID strobe count is not four, the number of EEPROM acknowledges differs from 0, 1, 65 or 66 for the stage where a probe should stop, or decode writes appear after a failed checksum. A wrong mask or interrupt decode is seen only when done rises, as a wrong pass flag, window value or written byte. This is why all 256 mask bytes are swept and each outcome is compared with a value computed arithmetically.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  parameter int unsigned PCS_AW   = 20;  // window address width
  parameter int unsigned PCS_SW   = 17;  // window size width (bytes)
  parameter int unsigned PCS_DW   = 16;  // EEPROM word width
  parameter int unsigned PCS_IDW  = 8;   // ID port width
  parameter int unsigned PCS_IRQW = 4;   // interrupt number width

  typedef enum logic [3:0] {
    S_IDLE, S_RST, S_ID, S_IDCHK, S_MEM, S_MEMCHK,
    S_SUM, S_SUMCHK, S_WR, S_IRQ, S_IRQCHK, S_DONE
  } pcs_state_e;
endpackage

// File: rtl/pcs_id_lane.sv
module pcs_id_lane
  import pcs_pkg::*;
(
  input  logic [PCS_IDW-1:0] rd_byte,
  output logic [15:0]        lane
);
  // upper nibble steered to the slot named by the two low bits
  always_comb lane = 16'(rd_byte[7:4]) << {rd_byte[1:0], 2'b00};
endmodule

// File: rtl/pcs_mem_decode.sv
module pcs_mem_decode
  import pcs_pkg::*;
#(
  parameter logic [PCS_AW-1:0] ORIGIN     = 20'hC0000,
  parameter int unsigned       PAGE_SHIFT = 14
) (
  input  logic [7:0]        mask,
  output logic              ok,
  output logic [PCS_AW-1:0] base,
  output logic [PCS_SW-1:0] size,
  output logic [7:0]        lo,
  output logic [7:0]        inv,
  output logic [7:0]        ext
);
  logic [2:0]  idx;
  logic        found;
  logic [7:0]  run;
  logic [2:0]  units;
  logic [3:0]  pg;
  logic [15:0] dec;

  always_comb begin
    idx   = '0;
    found = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (!found && mask[i]) begin
        idx   = 3'(i);
        found = 1'b1;
      end
    end
    run = mask >> idx;
    case (run)
      8'h01:   units = 3'd1;
      8'h03:   units = 3'd2;
      8'h07:   units = 3'd3;
      8'h0F:   units = 3'd4;
      default: units = 3'd0;
    endcase
    ok   = found && (units != 3'd0);
    base = ORIGIN + (PCS_AW'(idx) << PAGE_SHIFT);
    size = PCS_SW'(units) << PAGE_SHIFT;
    pg   = base[PAGE_SHIFT+3:PAGE_SHIFT];
    dec  = ((16'd1 << units) - 16'd1) << pg;
    lo   = dec[7:0];
    inv  = ~dec[7:0];
    ext  = {~dec[11:8], 4'h0} | dec[15:8];
  end
endmodule

// File: rtl/pcs_irq_map.sv
module pcs_irq_map
  import pcs_pkg::*;
(
  input  logic [2:0]          code,
  output logic [PCS_IRQW-1:0] num
);
  always_comb begin
    case (code)
      3'd1:    num = 4'd9;
      3'd2:    num = 4'd3;
      3'd3:    num = 4'd4;
      3'd4:    num = 4'd5;
      3'd5:    num = 4'd10;
      3'd6:    num = 4'd11;
      default: num = 4'd0;
    endcase
  end
endmodule

// File: rtl/probe_cfg_seq.sv
module probe_cfg_seq
  import pcs_pkg::*;
#(
  parameter int unsigned RST_CYCLES = 8,
  parameter logic [15:0] ID_EXPECT  = 16'hBABA,
  parameter int unsigned EE_WORDS   = 64,
  parameter int unsigned MEM_WORD   = 6,
  parameter int unsigned IRQ_WORD   = 1,
  parameter int unsigned IRQ_LSB    = 13
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                pre_base_vld,
  input  logic [PCS_AW-1:0]   pre_base,
  input  logic                pre_size_vld,
  input  logic [PCS_SW-1:0]   pre_size,
  input  logic                pre_irq_vld,
  input  logic [PCS_IRQW-1:0] pre_irq,
  output logic                hw_reset,
  output logic                id_rd,
  input  logic [PCS_IDW-1:0]  id_data,
  output logic                ee_req,
  output logic [5:0]          ee_addr,
  input  logic                ee_ack,
  input  logic [PCS_DW-1:0]   ee_data,
  output logic                ctl_hold,
  output logic                reg_wr,
  output logic [1:0]          reg_sel,
  output logic [7:0]          reg_wdata,
  output logic                done,
  output logic                pass,
  output logic [PCS_AW-1:0]   win_base,
  output logic [PCS_SW-1:0]   win_size,
  output logic [7:0]          dec_lo,
  output logic [7:0]          dec_inv,
  output logic [7:0]          dec_ext,
  output logic [PCS_IRQW-1:0] irq_num
);
  localparam int unsigned EE_AW = $clog2(EE_WORDS);
  localparam int unsigned CNT_MAX = (RST_CYCLES > EE_WORDS) ? RST_CYCLES : EE_WORDS;
  localparam int unsigned CNT_W = $clog2(CNT_MAX + 1);

  pcs_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [15:0]       id_q, sum_q, lane;
  logic [7:0]        mask_q;
  logic [2:0]        code_q;
  logic              pass_q;
  logic              mem_ok;
  logic              acc_clr, id_en, mask_en, sum_clr, sum_en, code_en, pass_set, pass_clr;

  pcs_id_lane u_lane (.rd_byte(id_data), .lane(lane));

  pcs_mem_decode u_mem (
    .mask(mask_q), .ok(mem_ok), .base(win_base), .size(win_size),
    .lo(dec_lo), .inv(dec_inv), .ext(dec_ext)
  );

  pcs_irq_map u_irq (.code(code_q), .num(irq_num));

  // next-state and control strobes
  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    acc_clr  = 1'b0;
    id_en    = 1'b0;
    mask_en  = 1'b0;
    sum_clr  = 1'b0;
    sum_en   = 1'b0;
    code_en  = 1'b0;
    pass_set = 1'b0;
    pass_clr = 1'b0;
    case (state_q)
      S_IDLE, S_DONE: if (start) begin
        state_d  = S_RST;
        cnt_d    = '0;
        acc_clr  = 1'b1;
        pass_clr = 1'b1;
      end
      S_RST: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == CNT_W'(RST_CYCLES - 1)) begin
          state_d = S_ID;
          cnt_d   = '0;
        end
      end
      S_ID: begin
        id_en = 1'b1;
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == CNT_W'(3)) state_d = S_IDCHK;
      end
      S_IDCHK: state_d = (id_q == ID_EXPECT) ? S_MEM : S_DONE;
      S_MEM: if (ee_ack) begin
        mask_en = 1'b1;
        state_d = S_MEMCHK;
      end
      S_MEMCHK: begin
        if (!mem_ok || (pre_base_vld && pre_base != win_base) ||
            (pre_size_vld && pre_size != win_size)) begin
          state_d = S_DONE;
        end else begin
          state_d = S_SUM;
          cnt_d   = '0;
          sum_clr = 1'b1;
        end
      end
      S_SUM: if (ee_ack) begin
        sum_en = 1'b1;
        cnt_d  = cnt_q + 1'b1;
        if (cnt_q == CNT_W'(EE_WORDS - 1)) state_d = S_SUMCHK;
      end
      S_SUMCHK: begin
        cnt_d   = '0;
        state_d = (sum_q == ID_EXPECT) ? S_WR : S_DONE;
      end
      S_WR: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == CNT_W'(2)) state_d = S_IRQ;
      end
      S_IRQ: if (ee_ack) begin
        code_en = 1'b1;
        state_d = S_IRQCHK;
      end
      S_IRQCHK: begin
        state_d  = S_DONE;
        pass_set = !(pre_irq_vld && pre_irq != irq_num);
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q   <= '0;
      sum_q  <= '0;
      mask_q <= '0;
      code_q <= '0;
      pass_q <= 1'b0;
    end else begin
      if (acc_clr)     id_q   <= '0;
      else if (id_en)  id_q   <= id_q | lane;
      if (sum_clr)     sum_q  <= '0;
      else if (sum_en) sum_q  <= sum_q + ee_data;
      if (mask_en)     mask_q <= ee_data[7:0];
      if (code_en)     code_q <= ee_data[IRQ_LSB +: 3];
      if (pass_clr)    pass_q <= 1'b0;
      else if (pass_set) pass_q <= 1'b1;
    end
  end

  // port decode of the current state
  always_comb begin
    hw_reset = (state_q == S_RST);
    id_rd    = (state_q == S_ID);
    ee_req   = (state_q == S_MEM) || (state_q == S_SUM) || (state_q == S_IRQ);
    ctl_hold = (state_q == S_SUM) || (state_q == S_SUMCHK) || (state_q == S_WR) ||
               (state_q == S_IRQ) || (state_q == S_IRQCHK);
    reg_wr   = (state_q == S_WR);
    reg_sel  = reg_wr ? cnt_q[1:0] : 2'd0;
    done     = (state_q == S_DONE);
    pass     = pass_q;
    case (state_q)
      S_MEM:   ee_addr = 6'(MEM_WORD);
      S_SUM:   ee_addr = 6'(cnt_q[EE_AW-1:0]);
      S_IRQ:   ee_addr = 6'(IRQ_WORD);
      default: ee_addr = 6'd0;
    endcase
    case (reg_sel)
      2'd0:    reg_wdata = reg_wr ? dec_lo : 8'h00;
      2'd1:    reg_wdata = dec_inv;
      2'd2:    reg_wdata = dec_ext;
      default: reg_wdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/probe_cfg_seq_chk.sv
module probe_cfg_seq_chk #(
  parameter int unsigned RST_CYCLES = 8,
  parameter int unsigned MEM_WORD   = 6
) (
  input logic        clk,
  input logic        rst_n,
  input logic        hw_reset,
  input logic        id_rd,
  input logic        ee_req,
  input logic [5:0]  ee_addr,
  input logic        ee_ack,
  input logic        ctl_hold,
  input logic        reg_wr,
  input logic [1:0]  reg_sel,
  input logic        done,
  input logic        pass,
  input logic [16:0] win_size
);
  localparam int unsigned RUN_W = $clog2(RST_CYCLES + 2);
  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        run_q <= '0;
    else if (hw_reset) run_q <= run_q + 1'b1;
    else               run_q <= '0;
  end

  p_rst_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hw_reset |-> run_q < RUN_W'(RST_CYCLES));
  p_rst_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hw_reset) |-> run_q == RUN_W'(RST_CYCLES) && id_rd);
  p_phase_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hw_reset, id_rd, ee_req, reg_wr}));
  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ee_req && !ee_ack |=> ee_req && $stable(ee_addr));
  p_hold_sum_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ee_req && !ctl_hold |-> ee_addr == 6'(MEM_WORD));
  p_sel_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> reg_sel != 2'd3);
  p_pass_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pass |-> done);
  p_done_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !id_rd && !ee_req && !reg_wr && !hw_reset && !ctl_hold);
  p_pass_size_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pass |-> win_size == 17'h04000 || win_size == 17'h08000 ||
             win_size == 17'h0C000 || win_size == 17'h10000);
endmodule

bind probe_cfg_seq probe_cfg_seq_chk #(.RST_CYCLES(RST_CYCLES), .MEM_WORD(MEM_WORD)) u_chk (
  .clk(clk), .rst_n(rst_n), .hw_reset(hw_reset), .id_rd(id_rd), .ee_req(ee_req),
  .ee_addr(ee_addr), .ee_ack(ee_ack), .ctl_hold(ctl_hold), .reg_wr(reg_wr),
  .reg_sel(reg_sel), .done(done), .pass(pass), .win_size(win_size)
);

// File: tb/test_probe_cfg_seq.sv
`timescale 1ns/1ps
module test_probe_cfg_seq;
  localparam int RSTC = 8;
  localparam logic [15:0] IDV = 16'hBABA;

  logic clk = 1'b0;
  logic rst_n;
  logic start;
  logic pre_base_vld, pre_size_vld, pre_irq_vld;
  logic [19:0] pre_base;
  logic [16:0] pre_size;
  logic [3:0]  pre_irq;
  logic hw_reset, id_rd, ee_req, ee_ack, ctl_hold, reg_wr, done, pass;
  logic [7:0]  id_data, reg_wdata, dec_lo, dec_inv, dec_ext;
  logic [5:0]  ee_addr;
  logic [15:0] ee_data;
  logic [1:0]  reg_sel;
  logic [19:0] win_base;
  logic [16:0] win_size;
  logic [3:0]  irq_num;

  always #2.5 clk = ~clk;

  probe_cfg_seq #(.RST_CYCLES(RSTC), .ID_EXPECT(IDV)) i_probe_cfg_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .pre_base_vld(pre_base_vld), .pre_base(pre_base),
    .pre_size_vld(pre_size_vld), .pre_size(pre_size),
    .pre_irq_vld(pre_irq_vld), .pre_irq(pre_irq),
    .hw_reset(hw_reset), .id_rd(id_rd), .id_data(id_data),
    .ee_req(ee_req), .ee_addr(ee_addr), .ee_ack(ee_ack), .ee_data(ee_data),
    .ctl_hold(ctl_hold), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .done(done), .pass(pass), .win_base(win_base), .win_size(win_size),
    .dec_lo(dec_lo), .dec_inv(dec_inv), .dec_ext(dec_ext), .irq_num(irq_num)
  );

  // ID port and EEPROM responders
  logic [7:0]  id_img [0:3];
  logic [1:0]  id_idx;
  logic [15:0] rom [0:63];
  assign id_data = id_img[id_idx];

  always @(posedge clk) begin
    if (start) id_idx <= 2'd0;
    else if (id_rd) id_idx <= id_idx + 2'd1;
    if (ee_req && !ee_ack) begin
      ee_ack  <= 1'b1;
      ee_data <= rom[ee_addr];
    end else begin
      ee_ack  <= 1'b0;
    end
  end

  int checks = 0, errors = 0, cyc = 0;
  int n_rst, n_id, n_ack, n_bad, n_wr;
  logic [1:0] wsel [0:3];
  logic [7:0] wdat [0:3];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 190000) begin
        errors++;
        $display("FAIL watchdog R11 actual=%0d expected=done", cyc);
        finish_run();
      end
    end
  end

  task automatic set_ids(input logic [1:0] s0, s1, s2, s3, input logic [15:0] idv);
    logic [1:0] sl [0:3];
    sl[0] = s0; sl[1] = s1; sl[2] = s2; sl[3] = s3;
    for (int i = 0; i < 4; i++)
      id_img[i] = {4'((idv >> (4 * sl[i])) & 16'hF), 2'(i), sl[i]};
  endtask

  task automatic build_rom(input logic [7:0] mask, input logic [2:0] code);
    logic [15:0] s;
    s = 16'h0;
    for (int i = 0; i < 64; i++) rom[i] = 16'(i * 16'h0107 + 16'h0033);
    rom[6][7:0]   = mask;
    rom[1][15:13] = code;
    for (int i = 0; i < 63; i++) s = s + rom[i];
    rom[63] = IDV - s;
  endtask

  task automatic run_probe();
    int t;
    n_rst = 0; n_id = 0; n_ack = 0; n_bad = 0; n_wr = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    t = 0;
    while (!done && t < 3000) begin
      if (hw_reset) n_rst++;
      if (id_rd) n_id++;
      if (ee_req && ee_ack) n_ack++;
      if (ee_req && ee_addr != 6'd6 && !ctl_hold) n_bad++;
      if (reg_wr && n_wr < 4) begin
        wsel[n_wr] = reg_sel;
        wdat[n_wr] = reg_wdata;
      end
      if (reg_wr) n_wr++;
      @(negedge clk);
      t++;
    end
  endtask

  // stage: 0 stop after ID, 1 after mask read, 2 after checksum, 3 full run
  task automatic check_run(input string tag, input int stage, input logic exp_pass);
    int acks;
    acks = (stage == 0) ? 0 : (stage == 1) ? 1 : (stage == 2) ? 65 : 66;
    chk({tag, " R11 done"}, done, 1'b1);
    chk({tag, " R10 pass"}, pass, exp_pass);
    chk({tag, " R2 reset len"}, n_rst, RSTC);
    chk({tag, " R2 id reads"}, n_id, 4);
    chk({tag, " R12 acks"}, n_ack, acks);
    chk({tag, " R6 hold"}, n_bad, 0);
    chk({tag, " R7 writes"}, n_wr, (stage == 3) ? 3 : 0);
  endtask

  task automatic check_window(input string tag, input logic [7:0] mask);
    int idx, run, k;
    logic [15:0] dec, ext;
    idx = 0;
    while (idx < 8 && !mask[idx]) idx++;
    run = mask >> idx;
    k = $clog2(run + 1);
    dec = 16'(((1 << k) - 1) << idx);
    ext = ((~dec >> 4) & 16'h00F0) | (dec >> 8);
    chk({tag, " R4 base"}, win_base, 32'hC0000 + idx * 32'h4000);
    chk({tag, " R5 size"}, win_size, k * 16384);
    chk({tag, " R7 sel0"}, {wsel[0], wdat[0]}, {2'd0, dec[7:0]});
    chk({tag, " R7 sel1"}, {wsel[1], wdat[1]}, {2'd1, ~dec[7:0]});
    chk({tag, " R8 sel2"}, {wsel[2], wdat[2]}, {2'd2, ext[7:0]});
    chk({tag, " R8 ext port"}, dec_ext, ext[7:0]);
  endtask

  function automatic logic [3:0] irq_of(input logic [2:0] c);
    case (c)
      3'd1: return 4'd9;  3'd2: return 4'd3;  3'd3: return 4'd4;
      3'd4: return 4'd5;  3'd5: return 4'd10; 3'd6: return 4'd11;
      default: return 4'd0;
    endcase
  endfunction

  initial begin
    rst_n = 1'b0; start = 1'b0; ee_ack = 1'b0; ee_data = '0; id_idx = '0;
    pre_base_vld = 0; pre_size_vld = 0; pre_irq_vld = 0;
    pre_base = '0; pre_size = '0; pre_irq = '0;
    set_ids(2'd0, 2'd1, 2'd2, 2'd3, IDV);
    build_rom(8'h3C, 3'd3);
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {done, pass, hw_reset, id_rd, ee_req, ctl_hold, reg_wr}, 7'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 idle outputs", {done, pass, hw_reset, id_rd, ee_req, ctl_hold, reg_wr}, 7'b0);

    // R4 R5 R9: sweep every mask byte, interrupt code varies with it
    for (int m = 0; m < 256; m++) begin
      int idx, run;
      logic ok;
      idx = 0;
      while (idx < 8 && !m[idx]) idx++;
      run = (idx < 8) ? (m >> idx) : 0;
      ok = (run == 1) || (run == 3) || (run == 7) || (run == 15);
      build_rom(8'(m), 3'(m % 8));
      run_probe();
      check_run("R4 sweep", ok ? 3 : 1, ok);
      if (ok) begin
        check_window("R5 sweep", 8'(m));
        chk("R9 irq sweep", irq_num, irq_of(3'(m % 8)));
      end
    end

    // R3: permuted read order passes; duplicate slot or bad nibble fails
    build_rom(8'h3C, 3'd3);
    set_ids(2'd2, 2'd0, 2'd3, 2'd1, IDV);
    run_probe();  check_run("R3 permuted", 3, 1'b1);
    set_ids(2'd0, 2'd1, 2'd1, 2'd3, IDV);
    run_probe();  check_run("R3 dup slot", 0, 1'b0);
    set_ids(2'd0, 2'd1, 2'd2, 2'd3, IDV ^ 16'h0100);
    run_probe();  check_run("R3 bad nibble", 0, 1'b0);
    set_ids(2'd0, 2'd1, 2'd2, 2'd3, IDV);

    // R6: corrupted checksum
    rom[20] = rom[20] ^ 16'h0001;
    run_probe();  check_run("R6 bad sum", 2, 1'b0);
    build_rom(8'h3C, 3'd3);

    // R10: presets
    pre_base_vld = 1; pre_base = 20'hC8000;
    pre_size_vld = 1; pre_size = 17'h10000;
    pre_irq_vld = 1;  pre_irq = 4'd4;
    run_probe();  check_run("R10 all match", 3, 1'b1);
    chk("R9 irq code3", irq_num, 4'd4);
    pre_base = 20'hCC000;
    run_probe();  check_run("R10 base diff", 1, 1'b0);
    pre_base = 20'hC8000; pre_size = 17'h0C000;
    run_probe();  check_run("R10 size diff", 1, 1'b0);
    pre_size = 17'h10000; pre_irq = 4'd5;
    run_probe();  check_run("R10 irq diff", 3, 1'b0);
    pre_base_vld = 0; pre_size_vld = 0; pre_irq_vld = 0;

    // R11: result held until next start
    run_probe();
    repeat (6) @(negedge clk);
    chk("R11 done held", {done, pass}, 2'b11);
    chk("R11 quiet", {hw_reset, id_rd, ee_req, reg_wr}, 4'b0);

    finish_run();
  end
endmodule